// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers 32 level-sensitive interrupt lines and presents them to a processor as two independent request outputs: a normal interrupt request and a fast interrupt request. Each output has its own 32-bit enable mask. A line reaches an output only while the line is high and its bit in that output's mask is set. Either output is the OR of its masked lines.

Software reaches the block through a simple word-addressed register bus. A write is a single-cycle strobe with a word address and 32 bits of data. A read is combinational from the current word address. The masks are never written directly. One address sets the mask bits written as 1, and another address clears them. Status words return the masked view and the raw view of the line levels.

A software-pending flag is merged into line 0, so firmware can raise an interrupt on itself. Hardware input 0 and the software flag are ORed together. Clearing the flag therefore never hides an active hardware input 0. The bus is a plain control path with no handshake: every write takes effect on the clock edge it is sampled on.

Top module: `dual_lvl_intc`

## Requirements
- R1: After reset both masks and the software flag are zero and both outputs are low.
- R2: Word 1 and word 9 read the level vector. Each bit is high while its input is high. Bit 0 is input 0 ORed with the software flag.
- R3: Word 0 reads level AND normal mask, and word 2 reads the normal mask.
- R4: A write to word 2 ORs the data into the normal mask, and a write to word 3 clears the normal mask bits written as 1. Mask bits written as 0 keep their value.
- R5: Word 8 reads level AND fast mask, and word 10 reads the fast mask. A write to word 10 sets fast mask bits, and a write to word 11 clears them (write-1 semantics).
- R6: A write to word 4 with data bit 0 set raises the software flag. A write to word 5 with data bit 0 set drops it. Such writes with bit 0 clear change nothing. Word 4 reads bit 0 of the level vector in bit 0, with zeros above.
- R7: The normal output is registered. In the cycle after any clock edge it equals the OR of (level AND normal mask) as sampled at that edge, using the mask value from before any write at that edge.
- R8: The fast output follows the same rule with the fast mask.
- R9: Words 3, 5, 11 and every unmapped word read zero. Writes to words 0, 1, 8 and 9 change no state.
- R10: With input 0 high, clearing the software flag leaves bit 0 of the level vector set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Level-sensitive interrupt inputs |
| reg_wr | input | 1 | Write strobe, one write per asserted cycle |
| reg_addr | input | 6 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| norm_req | output | 1 | Registered normal interrupt request |
| fast_req | output | 1 | Registered fast interrupt request |

## Verification
Two events can land on the same clock edge: an input level change and a write that sets or clears a mask bit for that input. The output then has to reflect the mask as it was before the write, with the new mask showing one edge later. The bench forces this case by toggling random lines while it writes random set and clear patterns at the same edges. A behavioural model takes the pre-edge mask and compares both outputs and the read data on every cycle. The same pressure is applied with the software flag being cleared while hardware input 0 is held high.

// File: rtl/dlic_pkg.sv
package dlic_pkg;
  localparam int unsigned LINES = 32;
  localparam int unsigned AW    = 6;

  typedef logic [AW-1:0] waddr_t;

  localparam waddr_t W_NSTAT = 6'd0;
  localparam waddr_t W_RAW   = 6'd1;
  localparam waddr_t W_NSET  = 6'd2;
  localparam waddr_t W_NCLR  = 6'd3;
  localparam waddr_t W_SWSET = 6'd4;
  localparam waddr_t W_SWCLR = 6'd5;
  localparam waddr_t W_FSTAT = 6'd8;
  localparam waddr_t W_FRAW  = 6'd9;
  localparam waddr_t W_FSET  = 6'd10;
  localparam waddr_t W_FCLR  = 6'd11;

  localparam int unsigned NOUT = 2;
  localparam waddr_t SET_OF [NOUT] = '{W_NSET, W_FSET};
  localparam waddr_t CLR_OF [NOUT] = '{W_NCLR, W_FCLR};
endpackage

// File: rtl/dlic_mask_bank.sv
module dlic_mask_bank #(
  parameter int unsigned W = 32,
  parameter int unsigned AW = 6,
  parameter logic [AW-1:0] SET_A = '0,
  parameter logic [AW-1:0] CLR_A = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  mask_o
);
  logic do_set, do_clr;
  assign do_set = wr_en && (wr_addr == SET_A);
  assign do_clr = wr_en && (wr_addr == CLR_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_o <= '0;
    else if (do_set) mask_o <= mask_o | wr_data;
    else if (do_clr) mask_o <= mask_o & ~wr_data;
  end

  a_r4_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    do_set |=> ((mask_o & $past(wr_data)) == $past(wr_data)));
  a_r4_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> ((mask_o & $past(wr_data)) == '0));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_set || do_clr) |=> $stable(mask_o));
endmodule

// File: rtl/dlic_swsrc.sv
module dlic_swsrc #(
  parameter int unsigned AW = 6,
  parameter logic [AW-1:0] SET_A = '0,
  parameter logic [AW-1:0] CLR_A = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit0,
  output logic          pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else if (wr_en && wr_bit0 && wr_addr == SET_A) pend_o <= 1'b1;
    else if (wr_en && wr_bit0 && wr_addr == CLR_A) pend_o <= 1'b0;
  end

  a_r6_sw_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bit0 && wr_addr == SET_A) |=> pend_o);
  a_r6_sw_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bit0 && wr_addr == CLR_A) |=> !pend_o);
  a_r6_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_bit0) |=> $stable(pend_o));
endmodule

// File: rtl/dlic_readmux.sv
module dlic_readmux
  import dlic_pkg::*;
(
  input  waddr_t           addr,
  input  logic [LINES-1:0] level,
  input  logic [LINES-1:0] nmask,
  input  logic [LINES-1:0] fmask,
  output logic [LINES-1:0] rdata
);
  always_comb begin
    unique case (addr)
      W_NSTAT:         rdata = level & nmask;
      W_RAW, W_FRAW:   rdata = level;
      W_NSET:          rdata = nmask;
      W_SWSET:         rdata = {{(LINES-1){1'b0}}, level[0]};
      W_FSTAT:         rdata = level & fmask;
      W_FSET:          rdata = fmask;
      default:         rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_lvl_intc.sv
module dual_lvl_intc
  import dlic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] irq_lines,
  input  logic        reg_wr,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        norm_req,
  output logic        fast_req
);
  logic             sw_pend;
  logic [LINES-1:0] level;
  logic [LINES-1:0] mask [NOUT];
  logic [NOUT-1:0]  req_q;

  dlic_swsrc #(.AW(AW), .SET_A(W_SWSET), .CLR_A(W_SWCLR)) u_sw (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_bit0(reg_wdata[0]), .pend_o(sw_pend));

  assign level = irq_lines | {{(LINES-1){1'b0}}, sw_pend};

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    dlic_mask_bank #(.W(LINES), .AW(AW), .SET_A(SET_OF[g]), .CLR_A(CLR_OF[g])) u_mask (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
      .wr_data(reg_wdata), .mask_o(mask[g]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q[g] <= 1'b0;
      else        req_q[g] <= |(level & mask[g]);
    end

    a_r7_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
      ((level & mask[g]) == '0) |=> !req_q[g]);
    a_r8_active_high: assert property (@(posedge clk) disable iff (!rst_n)
      ((level & mask[g]) != '0) |=> req_q[g]);
  end

  assign norm_req = req_q[0];
  assign fast_req = req_q[1];

  dlic_readmux u_rd (
    .addr(reg_addr), .level(level), .nmask(mask[0]), .fmask(mask[1]),
    .rdata(reg_rdata));

  a_r10_line0_kept: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lines[0] |-> level[0]);
  a_r9_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == W_NCLR || reg_addr == W_SWCLR || reg_addr == W_FCLR) |-> reg_rdata == '0);
endmodule

// File: tb/dual_lvl_intc_tb_top.sv
module dual_lvl_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        norm_req, fast_req;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_nm = '0, m_fm = '0;
  logic        m_sw = 1'b0, e_n = 1'b0, e_f = 1'b0;

  always #5 clk = ~clk;

  dual_lvl_intc dut_i (.*);

  function automatic logic [31:0] m_lvl();
    return irq_lines | {31'd0, m_sw};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_nm <= '0; m_fm <= '0; m_sw <= 1'b0; e_n <= 1'b0; e_f <= 1'b0;
    end else begin
      e_n <= (m_lvl() & m_nm) != 0;
      e_f <= (m_lvl() & m_fm) != 0;
      if (reg_wr) begin
        case (reg_addr)
          6'd2:  m_nm <= m_nm | reg_wdata;
          6'd3:  m_nm <= m_nm & ~reg_wdata;
          6'd10: m_fm <= m_fm | reg_wdata;
          6'd11: m_fm <= m_fm & ~reg_wdata;
          6'd4:  if (reg_wdata[0]) m_sw <= 1'b1;
          6'd5:  if (reg_wdata[0]) m_sw <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [5:0] a);
    logic [31:0] l = m_lvl();
    case (a)
      6'd0: return l & m_nm;
      6'd1, 6'd9: return l;
      6'd2: return m_nm;
      6'd4: return {31'd0, l[0]};
      6'd8: return l & m_fm;
      6'd10: return m_fm;
      default: return '0;
    endcase
  endfunction

  function automatic string rtag(input logic [5:0] a);
    case (a)
      6'd0, 6'd2: return "R3";
      6'd1, 6'd9: return "R2";
      6'd4: return "R6";
      6'd8, 6'd10: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R7", {31'd0, norm_req}, {31'd0, e_n});
    chk("R8", {31'd0, fast_req}, {31'd0, e_f});
    chk(rtag(reg_addr), reg_rdata, m_read(reg_addr));
  endtask

  // one cycle: compare current state, then drive the next stimulus
  task automatic step(input logic w, input logic [5:0] a, input logic [31:0] d,
                      input logic [31:0] lines);
    @(negedge clk);
    cmp_all();
    reg_wr = w; reg_addr = a; reg_wdata = d; irq_lines = lines;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] lines);
    step(1'b0, a, '0, lines);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1", {30'd0, norm_req, fast_req}, 32'd0);
    reg_addr = 6'd2; #1 chk("R1", reg_rdata, 32'd0);
    reg_addr = 6'd10; #1 chk("R1", reg_rdata, 32'd0);
    reg_addr = 6'd1; #1 chk("R1", reg_rdata, 32'd0);
    rst_n = 1'b1;

    // R2 raw level follows inputs
    rd(6'd1, 32'hA5A5_0F0E);
    rd(6'd9, 32'h0000_0000);
    // R4 set/clear normal mask
    step(1, 6'd2, 32'h0000_0F00, 32'h0000_0100);
    rd(6'd2, 32'h0000_0100);
    rd(6'd0, 32'h0000_0100);           // R7 norm_req rises
    step(1, 6'd3, 32'h0000_0100, 32'h0000_0100);
    rd(6'd2, 32'h0000_0100);
    // R5 fast mask
    step(1, 6'd10, 32'h8000_0001, 32'h8000_0000);
    rd(6'd8, 32'h8000_0000);
    step(1, 6'd11, 32'h8000_0000, 32'h8000_0000);
    rd(6'd10, 32'h8000_0000);
    // R9 writes to read-only words, reads of write-only words
    step(1, 6'd0, 32'hFFFF_FFFF, '0);
    step(1, 6'd1, 32'hFFFF_FFFF, '0);
    step(1, 6'd8, 32'hFFFF_FFFF, '0);
    step(1, 6'd9, 32'hFFFF_FFFF, '0);
    rd(6'd2, '0); rd(6'd10, '0); rd(6'd3, '0); rd(6'd5, '0); rd(6'd11, '0); rd(6'd63, '0);
    // R6 software flag; bit0 clear writes ignored
    step(1, 6'd4, 32'hFFFF_FFFE, '0);
    rd(6'd4, '0);
    step(1, 6'd4, 32'h1, '0);
    rd(6'd4, '0);
    rd(6'd1, '0);
    step(1, 6'd5, 32'hFFFF_FFFE, '0);
    rd(6'd4, '0);
    // R10 hardware line 0 survives software clear
    step(1, 6'd5, 32'h1, 32'h1);
    rd(6'd1, 32'h1);
    rd(6'd4, 32'h1);
    // mask write and level change on the same edge (R7, R8)
    step(1, 6'd2, 32'h0000_0002, 32'h0000_0002);
    step(1, 6'd3, 32'h0000_0002, 32'h0000_0002);
    rd(6'd0, 32'h0000_0002);
    // random mixed traffic compared every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] a;
      logic [31:0] d;
      int k = $urandom_range(0, 11);
      a = (k == 11) ? 6'($urandom_range(12, 63)) : 6'(k < 6 ? k : k + 2);
      d = ($urandom_range(0, 3) == 0) ? 32'(1 << $urandom_range(0, 31)) : $urandom();
      step(1'($urandom_range(0, 1)), a, d,
           ($urandom_range(0, 2) == 0) ? $urandom() : irq_lines);
    end
    rd(6'd1, '0);
    rd(6'd1, '0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule